// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller gathers 32 level-sensitive request lines. For each one it decides whether the line reaches the processor as a fast interrupt or as a normal interrupt. Each line can be enabled and disabled on its own. Software can also force a line high without any device driving it. Normal requests are ranked through 16 binding slots. Software assigns a source number to a slot, and the slot's index fixes its rank: index 0 ranks highest and index 15 lowest. Each slot also carries its own handler address.

A handler learns where to jump by reading the vector register. That read returns the address of the best-ranked enabled slot whose source is currently pending as a normal interrupt. When no slot matches, it returns the default handler address. The same read also records the rank that is now being served. While that rank is recorded, requests of equal or lower rank cannot raise the normal interrupt output. Any write to the vector register ends the service and clears the recorded rank.

All registers sit on a simple synchronous word bus. Writes take effect on the clock edge. Read data is combinational from the offset, and the side effect of a vector read happens on the edge at which the read is presented.

Top module: `prio_vector_irq`

## Requirements
- R1: After reset, every register reads zero, all sources are routed as normal interrupts, and both interrupt outputs are low.
- R2: Writing a 1 to a bit at the enable-set offset (0x03) enables that source. Writing a 1 at the enable-clear offset (0x04) disables it. Zero bits have no effect in either register. Reading 0x03 returns the current enables.
- R3: Writing a 1 at the soft-set offset (0x05) forces a request on that source. Writing a 1 at the soft-clear offset (0x06) removes the forced request. Zero bits have no effect. Reading 0x05 returns the forced set.
- R4: A 1 in the route register (0x02) sends that source to the fast output and to the fast status register (0x01). A 0 sends it to the normal output and to the normal status register (0x00).
- R5: A status bit is 1 exactly when its source is requesting (input line or forced), enabled, and routed to that status. The fast output is the OR of the fast status bits.
- R6: Slot control registers sit at 0x20+k and slot address registers at 0x10+k. In a control register, bits 4:0 hold the source number and bit 5 enables the slot. All other control bits read as zero.
- R7: A read of the vector register (0x07) returns the address of the lowest-index enabled slot whose source has its normal status bit set.
- R8: A disabled slot does not mask its source. A pending normal source with no enabled slot still raises the normal output, and a vector read returns the default address (0x08), unless some enabled slot also hits.
- R9: After a vector read, pending requests of the same or lower rank keep the normal output low. A request of strictly higher rank raises it again. Unslotted sources rank below slot 15.
- R10: Any write to the vector register, whatever its data, ends the hold, and the normal output again follows the normal status.
- R11: Reads of unmapped offsets (0x09 to 0x0F and 0x30 to 0x3F) return zero.
- R12: A fast-routed source never raises the normal output and never takes part in the vector choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 6 | Word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the offset presented |
| reqIn | input | 32 | Level request lines, one per source |
| irqOut | output | 1 | Normal interrupt to the processor |
| fiqOut | output | 1 | Fast interrupt to the processor |

## Verification
The hardest state to reach is a rank hold that is still active while requests arrive above, at and below the recorded rank. In that state the output level must follow rank, not merely whether something is pending. The bench reaches it by programming all 16 slots with distinct sources and reading the vector, so that a hold is recorded at a known slot. It then raises an unslotted source, a same-rank source and a higher-rank source one at a time and samples the output after each. The slot-pair sweep covers every ordered pair of slots, so every rank comparison in the winner search is exercised.

// File: rtl/pvic_pkg.sv
`timescale 1ns/1ps
package pvic_pkg;
  localparam int OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_NORM_STAT = 6'h00;
  localparam logic [OFS_W-1:0] OFS_FAST_STAT = 6'h01;
  localparam logic [OFS_W-1:0] OFS_ROUTE     = 6'h02;
  localparam logic [OFS_W-1:0] OFS_EN_SET    = 6'h03;
  localparam logic [OFS_W-1:0] OFS_EN_CLR    = 6'h04;
  localparam logic [OFS_W-1:0] OFS_SOFT_SET  = 6'h05;
  localparam logic [OFS_W-1:0] OFS_SOFT_CLR  = 6'h06;
  localparam logic [OFS_W-1:0] OFS_VECTOR    = 6'h07;
  localparam logic [OFS_W-1:0] OFS_DEFAULT   = 6'h08;
  // offset[5:4] selects a slot bank, offset[3:0] the slot
  localparam logic [1:0] BANK_SLOT_ADDR = 2'b01;
  localparam logic [1:0] BANK_SLOT_CTL  = 2'b10;
  localparam int CTL_EN_BIT = 5;

  typedef struct packed {
    logic       wrRoute;
    logic       wrEnSet;
    logic       wrEnClr;
    logic       wrSoftSet;
    logic       wrSoftClr;
    logic       wrDefault;
    logic       wrSlotAddr;
    logic       wrSlotCtl;
    logic [3:0] slotIdx;
  } strobe_t;
endpackage

// File: rtl/pvic_control.sv
`timescale 1ns/1ps
module pvic_control
  import pvic_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  parameter int LEVEL_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [OFS_W-1:0]   busAddr,
  input  logic [LEVEL_W-1:0] winLevel,
  output strobe_t            strb,
  output logic               holdValid,
  output logic [LEVEL_W-1:0] holdLevel
);
  localparam logic [4:0] SLOT_LIM = NUM_SLOT[4:0];

  logic slotInRange;
  logic vecRead;
  logic vecAck;

  assign slotInRange = ({1'b0, busAddr[3:0]} < SLOT_LIM);

  always_comb begin
    strb         = '0;
    strb.slotIdx = busAddr[3:0];
    vecRead      = busSel && !busWr && (busAddr == OFS_VECTOR);
    vecAck       = busSel && busWr && (busAddr == OFS_VECTOR);
    if (busSel && busWr) begin
      case (busAddr)
        OFS_ROUTE:    strb.wrRoute   = 1'b1;
        OFS_EN_SET:   strb.wrEnSet   = 1'b1;
        OFS_EN_CLR:   strb.wrEnClr   = 1'b1;
        OFS_SOFT_SET: strb.wrSoftSet = 1'b1;
        OFS_SOFT_CLR: strb.wrSoftClr = 1'b1;
        OFS_DEFAULT:  strb.wrDefault = 1'b1;
        default: begin
          strb.wrSlotAddr = (busAddr[5:4] == BANK_SLOT_ADDR) && slotInRange;
          strb.wrSlotCtl  = (busAddr[5:4] == BANK_SLOT_CTL) && slotInRange;
        end
      endcase
    end
  end

  // Rank hold: set by a vector read, released by any vector write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdLevel <= '0;
    end else if (vecAck) begin
      holdValid <= 1'b0;
      holdLevel <= '0;
    end else if (vecRead) begin
      holdValid <= 1'b1;
      holdLevel <= winLevel;
    end
  end

  AST_READ_SETS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    vecRead |=> holdValid); // R9
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    vecAck |=> !holdValid); // R10
  AST_HOLD_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> (holdLevel <= LEVEL_W'(NUM_SLOT))); // R9
endmodule

// File: rtl/pvic_datapath.sv
`timescale 1ns/1ps
module pvic_datapath
  import pvic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int LEVEL_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [OFS_W-1:0]   busAddr,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               holdValid,
  input  logic [LEVEL_W-1:0] holdLevel,
  output logic [LEVEL_W-1:0] winLevel,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int SRC_IW = $clog2(NUM_SRC);
  localparam logic [4:0] SLOT_LIM = NUM_SLOT[4:0];

  logic [NUM_SRC-1:0] routeReg, enReg, softReg, defAddr;
  logic [NUM_SRC-1:0] pend, normStat, fastStat, winAddr;
  logic [NUM_SRC-1:0] slotAddr [NUM_SLOT];
  logic [SRC_IW-1:0]  slotSrc  [NUM_SLOT];
  logic [NUM_SLOT-1:0] slotOn, slotHit, aboveHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeReg <= '0;
      enReg    <= '0;
      softReg  <= '0;
      defAddr  <= '0;
    end else begin
      if (strb.wrRoute)   routeReg <= busWdata;
      if (strb.wrEnSet)   enReg    <= enReg | busWdata;
      if (strb.wrEnClr)   enReg    <= enReg & ~busWdata;
      if (strb.wrSoftSet) softReg  <= softReg | busWdata;
      if (strb.wrSoftClr) softReg  <= softReg & ~busWdata;
      if (strb.wrDefault) defAddr  <= busWdata;
    end
  end

  assign pend     = (reqIn | softReg) & enReg;
  assign normStat = pend & ~routeReg;
  assign fastStat = pend & routeReg;
  assign fiqOut   = |fastStat;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotAddr[k] <= '0;
        slotSrc[k]  <= '0;
        slotOn[k]   <= 1'b0;
      end else begin
        if (strb.wrSlotAddr && strb.slotIdx == 4'(k)) slotAddr[k] <= busWdata;
        if (strb.wrSlotCtl && strb.slotIdx == 4'(k)) begin
          slotSrc[k] <= busWdata[SRC_IW-1:0];
          slotOn[k]  <= busWdata[CTL_EN_BIT];
        end
      end
    end
    assign slotHit[k]   = slotOn[k] && normStat[slotSrc[k]];
    assign aboveHold[k] = (LEVEL_W'(k) < holdLevel);
  end

  // Lowest index wins; no hit leaves the default at the bottom rank
  always_comb begin
    winLevel = LEVEL_W'(NUM_SLOT);
    winAddr  = defAddr;
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      if (slotHit[k]) begin
        winLevel = LEVEL_W'(k);
        winAddr  = slotAddr[k];
      end
    end
  end

  assign irqOut = holdValid ? |(slotHit & aboveHold) : |normStat;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_NORM_STAT: busRdata = normStat;
      OFS_FAST_STAT: busRdata = fastStat;
      OFS_ROUTE:     busRdata = routeReg;
      OFS_EN_SET:    busRdata = enReg;
      OFS_SOFT_SET:  busRdata = softReg;
      OFS_VECTOR:    busRdata = winAddr;
      OFS_DEFAULT:   busRdata = defAddr;
      default: begin
        if ({1'b0, busAddr[3:0]} < SLOT_LIM) begin
          if (busAddr[5:4] == BANK_SLOT_ADDR) busRdata = slotAddr[busAddr[3:0]];
          if (busAddr[5:4] == BANK_SLOT_CTL) begin
            busRdata[SRC_IW-1:0] = slotSrc[busAddr[3:0]];
            busRdata[CTL_EN_BIT] = slotOn[busAddr[3:0]];
          end
        end
      end
    endcase
  end

  AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnClr |=> ((enReg & $past(busWdata)) == '0)); // R2
  AST_SOFT_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSoftSet |=> ((softReg & $past(busWdata)) == $past(busWdata))); // R3
  AST_IRQ_NEEDS_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|normStat)); // R12
  AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (|(routeReg & enReg))); // R4
  AST_ROUTE_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRoute |=> (routeReg == $past(busWdata))); // R4
endmodule

// File: rtl/prio_vector_irq.sv
`timescale 1ns/1ps
module prio_vector_irq
  import pvic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [OFS_W-1:0]   busAddr,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int LEVEL_W = $clog2(NUM_SLOT + 1);

  strobe_t            strb;
  logic               holdValid;
  logic [LEVEL_W-1:0] holdLevel;
  logic [LEVEL_W-1:0] winLevel;

  pvic_control #(.NUM_SLOT(NUM_SLOT), .LEVEL_W(LEVEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .winLevel(winLevel), .strb(strb), .holdValid(holdValid), .holdLevel(holdLevel)
  );

  pvic_datapath #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .LEVEL_W(LEVEL_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .reqIn(reqIn), .holdValid(holdValid), .holdLevel(holdLevel),
    .winLevel(winLevel), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/prio_vector_irq_test.sv
`timescale 1ns/1ps
module prio_vector_irq_test;
  localparam logic [5:0] A_NORM = 6'h00, A_FAST = 6'h01, A_ROUTE = 6'h02, A_ENS = 6'h03,
    A_ENC = 6'h04, A_SFS = 6'h05, A_SFC = 6'h06, A_VEC = 6'h07, A_DEF = 6'h08;
  localparam logic [31:0] DEF_ADDR = 32'hDEF0_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] reqIn = '0;
  logic irqOut, fiqOut;
  int nChecks = 0, nFail = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  prio_vector_irq uut (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .reqIn(reqIn),
    .irqOut(irqOut), .fiqOut(fiqOut));

  function automatic int srcOf(input int k); return (k * 7 + 3) % 32; endfunction
  function automatic logic [31:0] slotAd(input int k); return 32'h4000_0000 + 32'(k * 16); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic setReq(input logic [31:0] v);
    reqIn = v; #1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1 irqOut", {31'b0, irqOut}, 0);
    check("R1 fiqOut", {31'b0, fiqOut}, 0);
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), rv);
      check((a >= 9 && a < 16) || a >= 48 ? "R11 unmapped" : "R1 reset read", rv, 0);
    end
    wr(A_VEC, 0);

    // R2 enable set / clear
    wr(A_ENS, 32'hA5A5_0F0F); rd(A_ENS, rv); check("R2 set", rv, 32'hA5A5_0F0F);
    wr(A_ENS, 0);             rd(A_ENS, rv); check("R2 set zero", rv, 32'hA5A5_0F0F);
    wr(A_ENC, 32'h0000_0F00); rd(A_ENS, rv); check("R2 clear", rv, 32'hA5A5_000F);
    wr(A_ENC, 0);             rd(A_ENS, rv); check("R2 clear zero", rv, 32'hA5A5_000F);
    wr(A_ENC, 32'hFFFF_FFFF); rd(A_ENS, rv); check("R2 clear all", rv, 0);

    // R3 soft set / clear
    wr(A_SFS, 32'h1234_8001); rd(A_SFS, rv); check("R3 set", rv, 32'h1234_8001);
    wr(A_SFS, 0);             rd(A_SFS, rv); check("R3 set zero", rv, 32'h1234_8001);
    wr(A_SFC, 32'h0004_8000); rd(A_SFS, rv); check("R3 clear", rv, 32'h1230_0001);
    wr(A_SFC, 0);             rd(A_SFS, rv); check("R3 clear zero", rv, 32'h1230_0001);
    wr(A_SFC, 32'hFFFF_FFFF); rd(A_SFS, rv); check("R3 clear all", rv, 0);

    // Per-source sweep: routing, status, masking, forcing
    wr(A_DEF, DEF_ADDR);
    wr(A_ENS, 32'hFFFF_FFFF);
    for (int s = 0; s < 32; s++) begin
      logic [31:0] b;
      b = 32'h1 << s;
      setReq(b);
      rd(A_NORM, rv); check("R5 normal status", rv, b);
      check("R5 irq", {31'b0, irqOut}, 1);
      check("R5 fiq idle", {31'b0, fiqOut}, 0);
      wr(A_ROUTE, b);
      rd(A_FAST, rv); check("R4 fast status", rv, b);
      rd(A_NORM, rv); check("R4 normal empty", rv, 0);
      check("R4 fiq", {31'b0, fiqOut}, 1);
      check("R12 irq low", {31'b0, irqOut}, 0);
      rd(A_VEC, rv); check("R12 vector default", rv, DEF_ADDR);
      wr(A_VEC, 0);
      wr(A_ROUTE, 0);
      wr(A_ENC, b);
      rd(A_NORM, rv); check("R5 disabled", rv, 0);
      check("R5 irq masked", {31'b0, irqOut}, 0);
      wr(A_ENS, b);
      setReq(0);
      wr(A_SFS, b);
      rd(A_NORM, rv); check("R3 forced status", rv, b);
      wr(A_SFC, b);
      rd(A_NORM, rv); check("R3 forced removed", rv, 0);
    end

    // R6 slot control field layout
    wr(6'h23, 32'hFFFF_FFFF); rd(6'h23, rv); check("R6 ctl bits", rv, 32'h0000_003F);
    wr(6'h13, 32'h1234_5678); rd(6'h13, rv); check("R6 addr", rv, 32'h1234_5678);

    // Program all slots
    for (int k = 0; k < 16; k++) begin
      wr(6'(16 + k), slotAd(k));
      wr(6'(32 + k), 32'h20 | 32'(srcOf(k)));
    end
    for (int k = 0; k < 16; k++) begin
      rd(6'(32 + k), rv); check("R6 ctl readback", rv, 32'h20 | 32'(srcOf(k)));
    end

    // R7 every ordered slot pair
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        setReq((32'h1 << srcOf(i)) | (32'h1 << srcOf(j)));
        check("R7 irq", {31'b0, irqOut}, 1);
        rd(A_VEC, rv); check("R7 vector", rv, slotAd(i < j ? i : j));
        wr(A_VEC, 0);
      end
    end

    // R8 disabled slot falls back to default
    for (int i = 0; i < 16; i++) begin
      int j;
      j = (i + 1) % 16;
      wr(6'(32 + i), 32'(srcOf(i)));
      setReq(32'h1 << srcOf(i));
      check("R8 irq unmasked", {31'b0, irqOut}, 1);
      rd(A_VEC, rv); check("R8 default", rv, DEF_ADDR);
      wr(A_VEC, 0);
      setReq((32'h1 << srcOf(i)) | (32'h1 << srcOf(j)));
      rd(A_VEC, rv); check("R8 slot beats default", rv, slotAd(j));
      wr(A_VEC, 0);
      wr(6'(32 + i), 32'h20 | 32'(srcOf(i)));
    end

    // R9 / R10 rank hold (slot2 src17, slot5 src6, src0 unslotted)
    setReq(32'h1 << 6);
    rd(A_VEC, rv); check("R9 vector slot5", rv, slotAd(5));
    check("R9 same rank held", {31'b0, irqOut}, 0);
    setReq((32'h1 << 6) | 32'h1);
    check("R9 lower rank held", {31'b0, irqOut}, 0);
    setReq((32'h1 << 6) | 32'h1 | (32'h1 << 17));
    check("R9 higher rank passes", {31'b0, irqOut}, 1);
    rd(A_VEC, rv); check("R9 vector slot2", rv, slotAd(2));
    check("R9 nested held", {31'b0, irqOut}, 0);
    wr(A_VEC, 32'hFFFF_FFFF);
    check("R10 released", {31'b0, irqOut}, 1);
    setReq(32'h1);
    rd(A_VEC, rv); check("R9 default vector", rv, DEF_ADDR);
    check("R9 default held", {31'b0, irqOut}, 0);
    setReq(32'h1 | (32'h1 << 6));
    check("R9 slot over default", {31'b0, irqOut}, 1);
    wr(A_VEC, 32'h0000_5A5A);
    check("R10 released again", {31'b0, irqOut}, 1);

    // R11 unmapped offsets after configuration
    wr(6'h0B, 32'hFFFF_FFFF);
    for (int a = 9; a < 16; a++) begin
      rd(6'(a), rv); check("R11 unmapped low", rv, 0);
    end
    for (int a = 48; a < 64; a++) begin
      rd(6'(a), rv); check("R11 unmapped high", rv, 0);
    end
    finishRun();
  end
endmodule